// File: doc/BRIEF.md
# SPI Status Flag Register Controller

This block holds the 16-bit status word of a serial peripheral interface port. Three sticky flags live in it: a transfer-complete flag, a write-collision flag and a mode-fault flag. Pulses from the shift engine set the flags. The CPU cannot set or clear a flag by writing the status word. Instead, it clears a flag with a two-step sequence. First it reads the status word while the flag shows 1, which arms that flag. Then it makes the matching access to the data register.

The controller also watches the slave-select input. When the port is enabled as a master and that pin is pulled low by another node, the controller raises the mode-fault flag. At the same moment it emits a single-cycle pulse, so that neighbouring logic can leave master mode. The shift engine, the data register storage and clock generation are outside this block. It only sees strobes and selects from a simple register bus, plus event pulses.

Top module: `spi_stat_ctrl`

## Requirements
- R1: After reset every flag and arm bit is 0. In the status word, the transfer-complete flag is bit 15, the write-collision flag is bit 14 and the mode-fault flag is bit 12. Every other bit always reads 0.
- R2: `rdata` is registered. In the cycle after a status read strobe it carries the flag values present at that strobe. After any other cycle it is 0.
- R3: A `xfer_done_evt` pulse sets the transfer-complete flag. When this flag is armed, a data register read or a data register write clears it.
- R4: A `coll_evt` pulse sets the write-collision flag. When armed, a data register read always clears it. A data register write clears it only if the transfer-complete flag was 1 at the arming status read, or a `xfer_done_evt` has occurred since that read.
- R5: The mode-fault condition is that `cfg_spi_en` and `cfg_master` are both high while the synchronized `ss_n` is low. The synchronizer has SYNC_STAGES flops. A rising edge of this condition produces exactly one cycle of `fault_pulse` and sets the mode-fault flag.
- R6: When armed, only a data register write clears the mode-fault flag. A data register read leaves it at 1.
- R7: A data register access with no preceding arming status read leaves every flag unchanged. A write strobe to the status register neither sets nor clears any flag.
- R8: If a set event and a clearing access reach a flag in the same cycle, the flag stays 1 and its arm bit is dropped.
- R9: While either `cfg_spi_en` or `cfg_master` is low, a low `ss_n` produces no `fault_pulse` and does not set the mode-fault flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| sel_stat | input | 1 | Selects the status register |
| sel_data | input | 1 | Selects the data register |
| xfer_done_evt | input | 1 | One-cycle pulse: a transfer has finished |
| coll_evt | input | 1 | One-cycle pulse: the data register was written during a transfer |
| ss_n | input | 1 | Asynchronous slave-select pin level, active low |
| cfg_spi_en | input | 1 | Port enable |
| cfg_master | input | 1 | Master mode selected |
| rdata | output | 16 | Registered status read data |
| fault_pulse | output | 1 | One-cycle pulse when a mode fault begins |

## Verification
The bench builds the block with the default SYNC_STAGES of 2. With that setting, a fall on `ss_n` reaches `fault_pulse` within a short, fixed window that the bench can count over.

The bench sweeps the collision-clearing rule across every combination of three choices:
- whether the transfer-complete flag was set before the arming read;
- whether a completion arrives after that read;
- whether the clearing access is a read or a write.

For each combination it computes the expected state of both flags arithmetically. Directed sequences cover the coincident set-and-clear case, unarmed accesses, status writes, and each combination of enable and master-mode settings for the fault detector.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  localparam int STAT_W    = 16;
  localparam int NFLAG     = 3;
  localparam int IDX_DONE  = 0;
  localparam int IDX_COLL  = 1;
  localparam int IDX_FAULT = 2;

  // Bit positions are visible to software, so they are fixed.
  localparam int POS_DONE  = 15;
  localparam int POS_COLL  = 14;
  localparam int POS_FAULT = 12;

  typedef logic [NFLAG-1:0]  flag_vec_t;
  typedef logic [STAT_W-1:0] stat_word_t;

  function automatic int flag_pos(input int idx);
    case (idx)
      IDX_DONE: flag_pos = POS_DONE;
      IDX_COLL: flag_pos = POS_COLL;
      default:  flag_pos = POS_FAULT;
    endcase
  endfunction

  function automatic stat_word_t pack_status(input flag_vec_t f);
    stat_word_t w;
    w = '0;
    for (int i = 0; i < NFLAG; i++) w[flag_pos(i)] = f[i];
    return w;
  endfunction

  function automatic stat_word_t stat_mask();
    return pack_status('1);
  endfunction

  // A read always clears the collision flag.
  // A write clears it only once a completion has been seen.
  function automatic logic coll_qualify(input logic seen, input logic rd, input logic wr);
    return rd | (seen & wr);
  endfunction
endpackage

// File: rtl/sstat_sync.sv
module sstat_sync #(
  parameter int   STAGES   = 2,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/sstat_flag.sv
module sstat_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic arm_req,
  input  logic clr_acc,
  output logic flag_q,
  output logic arm_q,
  output logic clr_evt
);
  // A clear happens only when an armed flag meets its qualifying access.
  assign clr_evt = arm_q & clr_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      // A set event takes priority over a clear in the same cycle.
      if (set_evt)      flag_q <= 1'b1;
      else if (clr_evt) flag_q <= 1'b0;

      // The arm bit is dropped whenever a clearing access lands.
      // It is captured only if the flag reads 1 at the status read.
      if (clr_evt)                arm_q <= 1'b0;
      else if (arm_req && flag_q) arm_q <= 1'b1;
    end
  end
endmodule

// File: rtl/sstat_fault_det.sv
module sstat_fault_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ss_n,
  input  logic spi_en,
  input  logic master,
  output logic ss_sync,
  output logic fault_cond,
  output logic fault_evt
);
  logic cond_d;

  sstat_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(ss_n), .q_sync(ss_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_cond <= 1'b0;
      cond_d     <= 1'b0;
    end else begin
      fault_cond <= spi_en & master & ~ss_sync;
      cond_d     <= fault_cond;
    end
  end

  assign fault_evt = fault_cond & ~cond_d;
endmodule

// File: rtl/spi_stat_ctrl.sv
module spi_stat_ctrl
  import spi_stat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              sel_stat,
  input  logic              sel_data,
  input  logic              xfer_done_evt,
  input  logic              coll_evt,
  input  logic              ss_n,
  input  logic              cfg_spi_en,
  input  logic              cfg_master,
  output logic [STAT_W-1:0] rdata,
  output logic              fault_pulse
);
  // Bus decode.
  logic stat_rd, data_rd, data_wr;
  assign stat_rd = bus_rd & sel_stat;
  assign data_rd = bus_rd & sel_data;
  assign data_wr = bus_wr & sel_data;

  // Mode-fault detection.
  logic ss_sync, fault_cond, fault_evt;
  sstat_fault_det #(.SYNC_STAGES(SYNC_STAGES)) u_fault (
    .clk(clk), .rst_n(rst_n), .ss_n(ss_n),
    .spi_en(cfg_spi_en), .master(cfg_master),
    .ss_sync(ss_sync), .fault_cond(fault_cond), .fault_evt(fault_evt)
  );
  assign fault_pulse = fault_evt;

  // Records whether a completion was seen after the collision flag was armed.
  logic seen_q, coll_seen_cap;
  flag_vec_t flags, arms, clr_evts, set_v, acc_v;

  assign coll_seen_cap = stat_rd & flags[IDX_COLL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             seen_q <= 1'b0;
    else if (coll_seen_cap) seen_q <= flags[IDX_DONE] | xfer_done_evt;
    else if (xfer_done_evt) seen_q <= 1'b1;
  end

  always_comb begin
    set_v            = '0;
    acc_v            = '0;
    set_v[IDX_DONE]  = xfer_done_evt;
    set_v[IDX_COLL]  = coll_evt;
    set_v[IDX_FAULT] = fault_evt;
    acc_v[IDX_DONE]  = data_rd | data_wr;
    acc_v[IDX_COLL]  = coll_qualify(seen_q, data_rd, data_wr);
    acc_v[IDX_FAULT] = data_wr;
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    sstat_flag u_flag (
      .clk(clk), .rst_n(rst_n),
      .set_evt(set_v[g]), .arm_req(stat_rd), .clr_acc(acc_v[g]),
      .flag_q(flags[g]), .arm_q(arms[g]), .clr_evt(clr_evts[g])
    );
  end

  // Registered readback, driven to zero when no status read took place.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata <= '0;
    else if (stat_rd) rdata <= pack_status(flags);
    else              rdata <= '0;
  end
endmodule

// File: rtl/spi_stat_ctrl_chk.sv
module spi_stat_ctrl_chk
  import spi_stat_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              stat_rd,
  input logic              data_rd,
  input logic              data_wr,
  input logic              xfer_done_evt,
  input logic              coll_evt,
  input logic [NFLAG-1:0]  flags,
  input logic [NFLAG-1:0]  arms,
  input logic [STAT_W-1:0] rdata,
  input logic              fault_pulse
);
  a_r1_unused_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~stat_mask()) == '0);

  a_r2_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> rdata == '0);

  a_r3_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done_evt |=> flags[IDX_DONE]);

  a_r4_coll_sets: assert property (@(posedge clk) disable iff (!rst_n)
    coll_evt |=> flags[IDX_COLL]);

  a_r5_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |=> !fault_pulse);

  a_r5_pulse_sets_fault: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |=> flags[IDX_FAULT]);

  a_r6_fault_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    flags[IDX_FAULT] && !data_wr |=> flags[IDX_FAULT]);

  a_r7_unarmed_keeps_done: assert property (@(posedge clk) disable iff (!rst_n)
    flags[IDX_DONE] && !arms[IDX_DONE] |=> flags[IDX_DONE]);

  a_r7_no_access_keeps_coll: assert property (@(posedge clk) disable iff (!rst_n)
    flags[IDX_COLL] && !data_rd && !data_wr |=> flags[IDX_COLL]);

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done_evt && arms[IDX_DONE] && (data_rd || data_wr)
      |=> flags[IDX_DONE] && !arms[IDX_DONE]);
endmodule

bind spi_stat_ctrl spi_stat_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .data_rd(data_rd),
  .data_wr(data_wr), .xfer_done_evt(xfer_done_evt), .coll_evt(coll_evt),
  .flags(flags), .arms(arms), .rdata(rdata), .fault_pulse(fault_pulse)
);

// File: tb/spi_stat_ctrl_bench.sv
`timescale 1ns/1ps
module spi_stat_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_rd = 0, bus_wr = 0, sel_stat = 0, sel_data = 0;
  logic xfer_done_evt = 0, coll_evt = 0;
  logic ss_n = 1, cfg_spi_en = 0, cfg_master = 0;
  logic [15:0] rdata;
  logic fault_pulse;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  spi_stat_ctrl u_spi_stat_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .sel_stat(sel_stat), .sel_data(sel_data), .xfer_done_evt(xfer_done_evt),
    .coll_evt(coll_evt), .ss_n(ss_n), .cfg_spi_en(cfg_spi_en),
    .cfg_master(cfg_master), .rdata(rdata), .fault_pulse(fault_pulse)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic stat_read(output logic [15:0] v);
    bus_rd = 1; sel_stat = 1; tick(); bus_rd = 0; sel_stat = 0; v = rdata;
  endtask
  task automatic stat_write();
    bus_wr = 1; sel_stat = 1; tick(); bus_wr = 0; sel_stat = 0;
  endtask
  task automatic data_read();
    bus_rd = 1; sel_data = 1; tick(); bus_rd = 0; sel_data = 0;
  endtask
  task automatic data_write();
    bus_wr = 1; sel_data = 1; tick(); bus_wr = 0; sel_data = 0;
  endtask
  task automatic pulse_done();
    xfer_done_evt = 1; tick(); xfer_done_evt = 0;
  endtask
  task automatic pulse_coll();
    coll_evt = 1; tick(); coll_evt = 0;
  endtask
  task automatic clear_all();
    logic [15:0] v;
    stat_read(v); data_read(); stat_read(v); data_write();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int pulses;
    repeat (3) tick();
    check("R1 reset rdata", rdata, 16'h0000);
    rst_n = 1; tick();
    stat_read(v); check("R1 reset flags", v, 16'h0000);

    // R7: a status write sets nothing.
    stat_write(); stat_read(v); check("R7 status write no set", v, 16'h0000);

    // R3 set; R7 an unarmed access keeps the flag.
    pulse_done(); data_read(); data_write();
    stat_read(v); check("R3 done set / R7 unarmed", v, 16'h8000);
    tick(); check("R2 idle rdata zero", rdata, 16'h0000);
    stat_write(); data_write();
    stat_read(v); check("R3 clear by write (R7 status write ignored)", v, 16'h0000);
    pulse_done(); stat_read(v); data_read();
    stat_read(v); check("R3 clear by read", v, 16'h0000);

    // R8: a coincident set and clear leaves the flag set with its arm dropped.
    pulse_done(); stat_read(v);
    bus_rd = 1; sel_data = 1; xfer_done_evt = 1; tick();
    bus_rd = 0; sel_data = 0; xfer_done_evt = 0;
    data_write();
    stat_read(v); check("R8 set wins, arm dropped", v, 16'h8000);
    clear_all();

    // R4 sweep over pre-set, post-event and access kind.
    for (int pre = 0; pre < 2; pre++)
      for (int post = 0; post < 2; post++)
        for (int acc = 0; acc < 2; acc++) begin
          logic coll_exp, done_exp;
          clear_all();
          if (pre != 0) pulse_done();
          pulse_coll();
          stat_read(v);
          check("R4 coll set", v & 16'h4000, 16'h4000);
          if (post != 0) pulse_done();
          if (acc == 0) data_read(); else data_write();
          coll_exp = !((acc == 0) || (pre != 0) || (post != 0));
          done_exp = (pre == 0) && (post != 0);
          stat_read(v);
          check("R4 coll clear rule", v & 16'h4000, coll_exp ? 16'h4000 : 16'h0000);
          check("R3 done in sweep", v & 16'h8000, done_exp ? 16'h8000 : 16'h0000);
        end
    clear_all();

    // R9: no fault unless the port is both enabled and in master mode.
    for (int cfg = 0; cfg < 3; cfg++) begin
      cfg_spi_en = (cfg == 1); cfg_master = (cfg == 2);
      ss_n = 0; pulses = 0;
      for (int k = 0; k < 8; k++) begin tick(); if (fault_pulse) pulses++; end
      check("R9 no pulse when disabled", 16'(pulses), 16'h0000);
      stat_read(v); check("R9 no fault flag", v, 16'h0000);
      ss_n = 1; repeat (4) tick();
    end

    // R5: the fault edge gives exactly one pulse and sets the flag.
    cfg_spi_en = 1; cfg_master = 1; tick();
    ss_n = 0; pulses = 0;
    for (int k = 0; k < 8; k++) begin tick(); if (fault_pulse) pulses++; end
    check("R5 single fault pulse", 16'(pulses), 16'h0001);
    stat_read(v); check("R5 fault flag set", v, 16'h1000);
    data_read();
    stat_read(v); check("R6 read keeps fault", v, 16'h1000);
    data_write();
    stat_read(v); check("R6 write clears fault", v, 16'h0000);
    repeat (4) tick();
    stat_read(v); check("R5 level held, no re-set", v, 16'h0000);
    ss_n = 1; cfg_spi_en = 0; cfg_master = 0; repeat (2) tick();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule